// File: doc/BRIEF.md
# Split-Search Longest Prefix Lookup Engine

This block resolves the next hop for a destination address in two phases: first it locates the length of the longest stored prefix that covers the address, then it reads the next hop that belongs to that prefix. Software prepares the tables and loads them through a simple write port. Lookups enter and results leave over valid/ready handshakes, one lookup in flight at a time.

Prefix lengths from zero up to one below a pivot level are each described by a presence bitmap and a matching next-hop array. The pivot level has one signed entry for every node: a positive value is the final next hop, zero means the match is shorter, and a negative value names a chunk of longer prefixes, all pushed down to full address length. When the pivot entry is zero, a small state machine probes the bitmaps one level per cycle, from just below the pivot down to the default route, and stops at the first set bit.

The default parameters (12-bit addresses, pivot at 8, 16-entry chunks) keep the tables small. The same code scales to 32-bit addresses with a pivot of 24 and 256-entry chunks.

Top module: `lpm_lookup`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: A lookup is accepted on a clock edge where `inValid` and `inReady` are both 1. `inReady` stays 0 from that edge until the result has been taken, and any request presented while busy is ignored: no further result appears for it.
- R3: While `outValid` is 1 and `outReady` is 0, `outValid`, `outHop` and `outLen` hold their values.
- R4: The pivot entry is read at index `inAddr >> (ADDR_W-PIVOT)`. If it is positive, the result is that value as next hop with length PIVOT, and `outValid` rises one cycle after the accepting edge.
- R5: If the pivot entry is negative, its magnitude C is a chunk number. The next hop is read from the long array at index (C-1)*2^(ADDR_W-PIVOT) plus the low ADDR_W-PIVOT address bits, the reported length is ADDR_W, and `outValid` rises two cycles after the accepting edge.
- R6: If the pivot entry is zero, the bitmaps are probed from level PIVOT-1 downward, one level per cycle. The first level L whose bit is 1 gives length L and the next hop stored for that node in the short array. `outValid` rises PIVOT-L+2 cycles after the accepting edge.
- R7: A write with `wrEn`=1 stores `wrData` into the table picked by `wrSel`: 0 = level bitmap (bit `wrData[0]`), 1 = short next-hop array, 2 = signed pivot entry, 3 = long next-hop array. Bitmap and short-array index for level L and address A is (2^L-1)+(A >> (ADDR_W-L)). Writes are seen by lookups accepted afterwards.
- R8: A scan that reaches level 0 ends there whatever the level-0 bit holds, and returns length 0 with the level-0 next hop.
- R9: Whenever `outValid` is 1, `outLen` is either at most PIVOT or equal to ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Lookup request present |
| inReady | output | 1 | Engine idle, request can be taken |
| inAddr | input | ADDR_W | Destination address to look up |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outHop | output | NH_W | Resolved next hop |
| outLen | output | LEN_W | Length of the matching prefix (ADDR_W for long chunks) |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 2 | Target table select |
| wrAddr | input | WA_W | Entry index in the selected table |
| wrData | input | ENT_W | Data to store (signed for the pivot table) |

## Verification
The main function is tried with addresses whose pivot entry is positive, negative with hits inside and outside the pushed long prefixes, and zero with matches at several depths down to the default route. The positive cases show the direct pivot path, the long cases show the chunk arithmetic picking the right entry against the pushed background value, and the zero cases show that the scan stops at the first set level rather than at a shallower one. Each vector also checks the cycle count, which distinguishes a scan that skips or repeats a level. Directed cases cover backpressure with a competing request, a table rewrite, and a scan that ends at a cleared default-route bit.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;        // capture address, read pivot entry
    logic probe;       // read one level bitmap bit
    logic stepDown;    // move to the next lower level
    logic fetchShort;  // read short next-hop array at current level
    logic fetchLong;   // read long next-hop array from chunk
    logic takePivot;   // result comes from the pivot entry
    logic takeFetch;   // result comes from the fetched next hop
  } lpm_strobe_t;

  // Conditions reported back to the controller
  typedef struct packed {
    logic pivotPos;
    logic pivotNeg;
    logic bitHit;
    logic levelZero;
  } lpm_status_t;

  typedef enum logic [1:0] {
    SEL_BITMAP = 2'd0,
    SEL_SHORT  = 2'd1,
    SEL_PIVOT  = 2'd2,
    SEL_LONG   = 2'd3
  } lpm_sel_e;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  input  lpm_status_t status,
  output lpm_strobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PIVOT, ST_SCAN, ST_FETCH, ST_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (inValid) begin
        strobe.load = 1'b1;
        stateNext   = ST_PIVOT;
      end
      ST_PIVOT: begin
        if (status.pivotPos) begin
          strobe.takePivot = 1'b1;
          stateNext        = ST_DONE;
        end else if (status.pivotNeg) begin
          strobe.fetchLong = 1'b1;
          stateNext        = ST_FETCH;
        end else begin
          strobe.probe = 1'b1;
          stateNext    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (status.bitHit || status.levelZero) begin
          strobe.fetchShort = 1'b1;
          stateNext         = ST_FETCH;
        end else begin
          strobe.stepDown = 1'b1;
          strobe.probe    = 1'b1;
        end
      end
      ST_FETCH: begin
        strobe.takeFetch = 1'b1;
        stateNext        = ST_DONE;
      end
      ST_DONE: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_DONE);

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PIVOT      = 8,
  parameter int NH_W       = 6,
  parameter int NUM_CHUNKS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lpm_strobe_t               strobe,
  output lpm_status_t               status,
  input  logic [ADDR_W-1:0]         inAddr,
  input  logic                      wrEn,
  input  logic [1:0]                wrSel,
  input  logic [((PIVOT > $clog2(NUM_CHUNKS*(1<<(ADDR_W-PIVOT)))) ? PIVOT : $clog2(NUM_CHUNKS*(1<<(ADDR_W-PIVOT))))-1:0] wrAddr,
  input  logic [NH_W:0]             wrData,
  output logic [NH_W-1:0]           outHop,
  output logic [$clog2(ADDR_W+1)-1:0] outLen
);

  localparam int CHUNK_W = ADDR_W - PIVOT;
  localparam int CHUNK_N = 1 << CHUNK_W;
  localparam int ENT_W   = NH_W + 1;
  localparam int SHORT_N = (1 << PIVOT) - 1;
  localparam int PIV_N   = 1 << PIVOT;
  localparam int LONG_N  = NUM_CHUNKS * CHUNK_N;
  localparam int LONG_AW = $clog2(LONG_N);
  localparam int LVL_W   = $clog2(PIVOT + 1);
  localparam int LEN_W   = $clog2(ADDR_W + 1);

  logic                    bitMem   [SHORT_N];
  logic [NH_W-1:0]         shortMem [SHORT_N];
  logic signed [ENT_W-1:0] pivMem   [PIV_N];
  logic [NH_W-1:0]         longMem  [LONG_N];

  logic [ADDR_W-1:0]       addrQ;
  logic signed [ENT_W-1:0] pivotQ;
  logic                    bitQ;
  logic [NH_W-1:0]         nhQ;
  logic [LVL_W-1:0]        levelQ;
  logic                    longQ;

  // Flattened position of the node covering address a on level lvl
  function automatic logic [PIVOT-1:0] levelIdx(input logic [LVL_W-1:0] lvl,
                                                input logic [ADDR_W-1:0] a);
    logic [PIVOT:0] base;
    logic [PIVOT:0] tag;
    base = ((PIVOT+1)'(1) << lvl) - (PIVOT+1)'(1);
    tag  = (PIVOT+1)'(a >> (ADDR_W - 32'(lvl)));
    return PIVOT'(base + tag);
  endfunction

  logic [LVL_W-1:0]   probeLvl;
  logic [ENT_W-1:0]   chunkM1;
  logic [LONG_AW-1:0] longIdx;

  assign probeLvl = strobe.stepDown ? levelQ - LVL_W'(1) : levelQ;
  assign chunkM1  = ENT_W'(-pivotQ) - ENT_W'(1);
  assign longIdx  = LONG_AW'({chunkM1, addrQ[CHUNK_W-1:0]});

  // Table writes
  always_ff @(posedge clk) begin
    if (wrEn) begin
      case (lpm_sel_e'(wrSel))
        SEL_BITMAP: bitMem[wrAddr[PIVOT-1:0]]    <= wrData[0];
        SEL_SHORT:  shortMem[wrAddr[PIVOT-1:0]]  <= wrData[NH_W-1:0];
        SEL_PIVOT:  pivMem[wrAddr[PIVOT-1:0]]    <= wrData;
        default:    longMem[wrAddr[LONG_AW-1:0]] <= wrData[NH_W-1:0];
      endcase
    end
  end

  // Synchronous table reads
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      addrQ  <= inAddr;
      pivotQ <= pivMem[inAddr[ADDR_W-1 -: PIVOT]];
    end
    if (strobe.probe)      bitQ <= bitMem[levelIdx(probeLvl, addrQ)];
    if (strobe.fetchShort) nhQ  <= shortMem[levelIdx(levelQ, addrQ)];
    if (strobe.fetchLong)  nhQ  <= longMem[longIdx];
  end

  // Level tracking and result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      longQ  <= 1'b0;
      outHop <= '0;
      outLen <= '0;
    end else begin
      if (strobe.load) begin
        levelQ <= LVL_W'(PIVOT - 1);
        longQ  <= 1'b0;
      end
      if (strobe.stepDown)  levelQ <= levelQ - LVL_W'(1);
      if (strobe.fetchLong) longQ  <= 1'b1;
      if (strobe.takePivot) begin
        outHop <= pivotQ[NH_W-1:0];
        outLen <= LEN_W'(PIVOT);
      end
      if (strobe.takeFetch) begin
        outHop <= nhQ;
        outLen <= longQ ? LEN_W'(ADDR_W) : LEN_W'(levelQ);
      end
    end
  end

  assign status.pivotPos  = !pivotQ[ENT_W-1] && (pivotQ != '0);
  assign status.pivotNeg  = pivotQ[ENT_W-1];
  assign status.bitHit    = bitQ;
  assign status.levelZero = (levelQ == '0);

endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PIVOT      = 8,
  parameter int NH_W       = 6,
  parameter int NUM_CHUNKS = 4,
  localparam int ENT_W     = NH_W + 1,
  localparam int LEN_W     = $clog2(ADDR_W + 1),
  localparam int LONG_AW   = $clog2(NUM_CHUNKS * (1 << (ADDR_W - PIVOT))),
  localparam int WA_W      = (PIVOT > LONG_AW) ? PIVOT : LONG_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [NH_W-1:0]   outHop,
  output logic [LEN_W-1:0]  outLen,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WA_W-1:0]   wrAddr,
  input  logic [ENT_W-1:0]  wrData
);

  lpm_strobe_t strobe;
  lpm_status_t status;

  lpm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe)
  );

  lpm_datapath #(
    .ADDR_W     (ADDR_W),
    .PIVOT      (PIVOT),
    .NH_W       (NH_W),
    .NUM_CHUNKS (NUM_CHUNKS)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status),
    .inAddr (inAddr),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .outHop (outHop),
    .outLen (outLen)
  );

endmodule

// File: rtl/lpm_lookup_checker.sv
module lpm_lookup_checker #(
  parameter int ADDR_W = 12,
  parameter int PIVOT  = 8,
  parameter int NH_W   = 6,
  parameter int LEN_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [NH_W-1:0]  outHop,
  input logic [LEN_W-1:0] outLen
);

  logic        busy;
  int unsigned cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= 0;
    end else if (inValid && inReady) begin
      busy <= 1'b1;
      cnt  <= 0;
    end else if (outValid && outReady) begin
      busy <= 1'b0;
    end else if (busy && !outValid) begin
      cnt <= cnt + 1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outHop) && $stable(outLen)); // R3

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady); // R2

  AST_ACCEPT_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !outValid); // R2

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (32'(outLen) <= PIVOT) || (32'(outLen) == ADDR_W)); // R9

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cnt <= PIVOT + 2); // R6

  AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy); // R2

endmodule

bind lpm_lookup lpm_lookup_checker #(
  .ADDR_W (ADDR_W),
  .PIVOT  (PIVOT),
  .NH_W   (NH_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outHop   (outHop),
  .outLen   (outLen)
);

// File: tb/lpm_lookup_bench.sv
`timescale 1ns/1ps
module lpm_lookup_bench;

  localparam int ADDR_W = 12;
  localparam int PIVOT  = 8;
  localparam int NH_W   = 6;
  localparam int NCH    = 4;
  localparam int LEN_W  = 4;
  localparam int WA_W   = 8;
  localparam int ENT_W  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady, outValid, outReady = 1'b1;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [NH_W-1:0]   outHop;
  logic [LEN_W-1:0]  outLen;
  logic              wrEn = 1'b0;
  logic [1:0]        wrSel = '0;
  logic [WA_W-1:0]   wrAddr = '0;
  logic [ENT_W-1:0]  wrData = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lpm_lookup #(.ADDR_W(ADDR_W), .PIVOT(PIVOT), .NH_W(NH_W), .NUM_CHUNKS(NCH)) u_lpm_lookup (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .outValid(outValid), .outReady(outReady), .outHop(outHop), .outLen(outLen),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData));

  // addr, expected length, expected hop, expected latency
  typedef struct packed {
    logic [11:0] addr;
    logic [3:0]  len;
    logic [5:0]  hop;
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{12'hA57, 4'd8,  6'd4,  8'd1},
    '{12'h7F3, 4'd8,  6'd10, 8'd1},
    '{12'hA62, 4'd12, 6'd5,  8'd2},
    '{12'hA6C, 4'd12, 6'd6,  8'd2},
    '{12'hA69, 4'd12, 6'd3,  8'd2},
    '{12'hFF8, 4'd12, 6'd9,  8'd2},
    '{12'hFF0, 4'd12, 6'd2,  8'd2},
    '{12'hA40, 4'd4,  6'd3,  8'd6},
    '{12'h305, 4'd7,  6'd7,  8'd3},
    '{12'h3F0, 4'd3,  6'd8,  8'd7},
    '{12'hC00, 4'd1,  6'd2,  8'd9},
    '{12'h000, 4'd0,  6'd1,  8'd10},
    '{12'h7E0, 4'd0,  6'd1,  8'd10}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrAddr = WA_W'(a); wrData = ENT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int bmIdx(input int lvl, input int a);
    return (1 << lvl) - 1 + (a >> (ADDR_W - lvl));
  endfunction

  task automatic setPrefix(input int lvl, input int a, input int hop);
    wr(0, bmIdx(lvl, a), 1);
    wr(1, bmIdx(lvl, a), hop);
  endtask

  // One lookup with outReady high; returns result and edges from accept to outValid
  task automatic lookup(input logic [11:0] a, output int len, output int hop, output int lat);
    int n;
    @(negedge clk);
    inValid = 1'b1; inAddr = a; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    n = 0;
    while (!outValid && n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    len = int'(outLen); hop = int'(outHop); lat = n;
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int len, hop, lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 inReady after reset", int'(inReady), 1);
    check("R1 outValid after reset", int'(outValid), 0);
    rstN = 1'b1;

    // R7: clear all tables, then load the prefix set
    for (int i = 0; i < 255; i++) begin wr(0, i, 0); wr(1, i, 0); end
    for (int i = 0; i < 256; i++) wr(2, i, 0);
    for (int i = 0; i < 64; i++)  wr(3, i, 0);
    setPrefix(0, 12'h000, 1);
    setPrefix(1, 12'h800, 2);
    setPrefix(3, 12'h200, 8);
    setPrefix(4, 12'hA00, 3);
    setPrefix(7, 12'h300, 7);
    wr(2, 8'hA5, 4);
    wr(2, 8'h7F, 10);
    wr(2, 8'hA6, -1);
    wr(2, 8'hFF, -2);
    for (int i = 0; i < 16; i++) wr(3, i, (i < 4) ? 5 : (i == 12) ? 6 : 3);
    for (int i = 0; i < 16; i++) wr(3, 16 + i, (i == 8) ? 9 : 2);

    // Table walk: R4 positive pivot, R5 chunks, R6 scan, R9 length range
    for (int v = 0; v < 13; v++) begin
      lookup(VEC[v].addr, len, hop, lat);
      check($sformatf("R4/R5/R6 vec %0d length", v), len, int'(VEC[v].len));
      check($sformatf("R4/R5/R6 vec %0d hop", v), hop, int'(VEC[v].hop));
      check($sformatf("R4/R5/R6 vec %0d latency", v), lat, int'(VEC[v].lat));
      check($sformatf("R9 vec %0d length range", v), int'(len <= PIVOT || len == ADDR_W), 1);
    end

    // R3 and R2: backpressure with a competing request while busy
    @(negedge clk);
    inValid = 1'b1; inAddr = 12'hA57; outReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    inAddr = 12'hFF8;
    check("R2 inReady low while busy", int'(inReady), 0);
    begin
      int n = 0;
      while (!outValid && n < 50) begin @(posedge clk); n++; @(negedge clk); end
    end
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3 outValid held", int'(outValid), 1);
      check("R3 outHop held", int'(outHop), 4);
      check("R3 outLen held", int'(outLen), 8);
      check("R2 inReady low while result waits", int'(inReady), 0);
    end
    inValid = 1'b0; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 result consumed, none for busy request", int'(outValid), 0);
    check("R2 idle again", int'(inReady), 1);
    repeat (4) @(negedge clk);
    check("R2 still no stray result", int'(outValid), 0);

    // R7: rewrite a pivot entry
    wr(2, 8'h7F, 11);
    lookup(12'h7F3, len, hop, lat);
    check("R7 rewritten pivot hop", hop, 11);
    check("R7 rewritten pivot length", len, 8);

    // R8: scan ends at level 0 even with its bit cleared
    wr(0, 0, 0);
    lookup(12'h7E0, len, hop, lat);
    check("R8 length at level 0", len, 0);
    check("R8 hop at level 0", hop, 1);
    check("R8 latency full scan", lat, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule